// File: doc/BRIEF.md
# Two-Lane Digit-Serial Adder

This block adds two unsigned operand streams one digit at a time. Each digit is a small group of adjacent bits, and the least significant digit of a word arrives first. With the default settings a word is 4 bits wide and a digit is 2 bits wide, so each word takes two valid cycles. Within a digit, lane j carries bit position j of that digit. With two lanes, lane 0 therefore holds the even bit positions and lane 1 holds the odd ones. The sum digit uses the same lane placement.

Inside one cycle the carry ripples through the lanes with no register between them. The carry out of the last lane passes through a single register and becomes the carry into lane 0 on the next valid digit. On the first digit of every word, the carry into lane 0 is forced to zero, so no carry passes from one word to the next. A digit counter tracks the position within the word. It advances only on cycles with valid input, so a stream may pause between digits. The sum digit is registered and comes out one cycle after its input digit.

Top module: `digit_serial_adder`

## Requirements
- R1: While reset is high on a clock edge, the block clears `sum_valid` and `sum_dig` to 0 after that edge. The next valid digit is then treated as the first digit (bits 1:0) of a new word.
- R2: `sum_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: In the digit of a word at index k (0 is first), bit j of `a_dig`, `b_dig` and `sum_dig` stands for word bit k*DIGIT_W + j. Lane 1 therefore carries the odd bit positions.
- R4: The carry into lane 0 is zero on the first digit of every word. The first sum digit equals the low DIGIT_W bits of a_dig + b_dig, whatever carry the previous word produced.
- R5: On the later digits of a word, the carry out of the top lane of the previous valid digit is added into lane 0. The concatenated sum digits of a word equal (A + B) mod 2^WORD_W.
- R6: A cycle with `in_valid` low leaves the digit position, the stored carry and `sum_dig` unchanged. A word whose digits are separated by idle cycles gives the same sum as a word sent back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The operand digits on this cycle are valid |
| a_dig | input | DIGIT_W | Digit of operand A, one bit per lane |
| b_dig | input | DIGIT_W | Digit of operand B, one bit per lane |
| sum_dig | output | DIGIT_W | Registered sum digit |
| sum_valid | output | 1 | `sum_dig` holds the result of the previous valid digit |

## Verification
The assertions assume that every word is delivered as exactly WORD_W/DIGIT_W valid digits, least significant first. A new word must start only after the previous one is complete or after a reset, because the digit position is inferred from counting valid cycles. The stimulus always sends whole words, in order. Idle cycles appear only between digits. The single mid-word break comes from asserting reset, which the block defines as a restart of the digit position.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

   typedef struct packed {
      logic carry;
      logic sum;
   } fa_result_t;

   function automatic fa_result_t fa_eval(input logic x, input logic y, input logic c);
      fa_result_t r;
      r.sum   = x ^ y ^ c;
      r.carry = (x & y) | (c & (x ^ y));
      return r;
   endfunction

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/dsa_fa.sv
module dsa_fa
   import dsa_pkg::*;
(
   input  logic x_i,
   input  logic y_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);

   fa_result_t res;

   always_comb begin
      res = fa_eval(x_i, y_i, c_i);
   end

   assign s_o = res.sum;
   assign c_o = res.carry;

endmodule

// File: rtl/dsa_lane_chain.sv
module dsa_lane_chain #(
   parameter int unsigned LANES = 2
) (
   input  logic [LANES-1:0] x_i,
   input  logic [LANES-1:0] y_i,
   input  logic             cin_i,
   output logic [LANES-1:0] sum_o,
   output logic             cout_o
);

   initial begin
      assert (LANES >= 1) else $error("dsa_lane_chain: LANES must be at least 1");
   end

   logic [LANES:0] rip;

   assign rip[0] = cin_i;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      dsa_fa u_fa (
         .x_i (x_i[g]),
         .y_i (y_i[g]),
         .c_i (rip[g]),
         .s_o (sum_o[g]),
         .c_o (rip[g+1])
      );
   end

   assign cout_o = rip[LANES];

endmodule

// File: rtl/dsa_slot_ctr.sv
module dsa_slot_ctr
   import dsa_pkg::*;
#(
   parameter int unsigned DPW = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic adv_i,
   output logic first_o
);

   localparam int unsigned SW = cnt_width(DPW);
   localparam logic [SW-1:0] LAST = SW'(DPW - 1);

   initial begin
      assert (DPW >= 2) else $error("dsa_slot_ctr: a word needs at least two digits");
   end

   logic [SW-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_q <= '0;
      end else if (adv_i) begin
         slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      end
   end

   assign first_o = (slot_q == '0);

   assert_slot_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !adv_i |=> $stable(slot_q));

   assert_slot_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      (adv_i && slot_q == LAST) |=> first_o);

endmodule

// File: rtl/digit_serial_adder.sv
module digit_serial_adder #(
   parameter int unsigned WORD_W  = 4,
   parameter int unsigned DIGIT_W = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [DIGIT_W-1:0] a_dig,
   input  logic [DIGIT_W-1:0] b_dig,
   output logic [DIGIT_W-1:0] sum_dig,
   output logic               sum_valid
);

   localparam int unsigned DPW = WORD_W / DIGIT_W;

   initial begin
      assert (DIGIT_W >= 1) else $error("digit_serial_adder: DIGIT_W must be positive");
      assert (WORD_W % DIGIT_W == 0) else $error("digit_serial_adder: WORD_W must be a multiple of DIGIT_W");
      assert (DPW >= 2) else $error("digit_serial_adder: WORD_W must span at least two digits");
   end

   logic               first_digit;
   logic               carry_q;
   logic               lane0_cin;
   logic [DIGIT_W-1:0] sum_c;
   logic               top_cout;

   dsa_slot_ctr #(.DPW(DPW)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .adv_i   (in_valid),
      .first_o (first_digit)
   );

   // Word boundary: the carry into lane 0 is forced low on the first digit.
   assign lane0_cin = first_digit ? 1'b0 : carry_q;

   dsa_lane_chain #(.LANES(DIGIT_W)) u_chain (
      .x_i    (a_dig),
      .y_i    (b_dig),
      .cin_i  (lane0_cin),
      .sum_o  (sum_c),
      .cout_o (top_cout)
   );

   // The only delay in the carry loop: top lane back to lane 0.
   always_ff @(posedge clk) begin
      if (rst) begin
         carry_q   <= 1'b0;
         sum_dig   <= '0;
         sum_valid <= 1'b0;
      end else begin
         sum_valid <= in_valid;
         if (in_valid) begin
            carry_q <= top_cout;
            sum_dig <= sum_c;
         end
      end
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!sum_valid && sum_dig == '0));

   assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> sum_valid);

   assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !sum_valid);

   assert_first_digit_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && first_digit) |=> sum_dig == DIGIT_W'($past(a_dig) + $past(b_dig)));

   assert_carry_digit_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !first_digit) |=>
         sum_dig == DIGIT_W'($past(a_dig) + $past(b_dig) + DIGIT_W'($past(carry_q))));

   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(sum_dig) && $stable(carry_q)));

endmodule

// File: tb/digit_serial_adder_test.sv
module digit_serial_adder_test;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [1:0] a_dig = '0;
   logic [1:0] b_dig = '0;
   logic [1:0] sum_dig;
   logic       sum_valid;

   int checks = 0;
   int errors = 0;

   logic       exp_valid = 1'b0;
   logic [1:0] exp_sum = '0;
   string      exp_tag = "R1";

   always #(CLK_P/2) clk = ~clk;

   digit_serial_adder #(.WORD_W(4), .DIGIT_W(2)) uut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .a_dig     (a_dig),
      .b_dig     (b_dig),
      .sum_dig   (sum_dig),
      .sum_valid (sum_valid)
   );

   task automatic check_out();
      checks++;
      if (sum_valid !== exp_valid) begin
         errors++;
         $display("FAIL %s (R2) sum_valid actual %0b expected %0b", exp_tag, sum_valid, exp_valid);
      end
      checks++;
      if (sum_dig !== exp_sum) begin
         errors++;
         $display("FAIL %s sum_dig actual %0d expected %0d", exp_tag, sum_dig, exp_sum);
      end
   endtask

   // Each tick: check the result of the previous cycle at the falling edge, then drive.
   task automatic tick(input logic r, input logic v, input logic [1:0] a, input logic [1:0] b,
                       input logic [1:0] e, input string tag);
      @(negedge clk);
      check_out();
      rst = r;
      in_valid = v;
      a_dig = a;
      b_dig = b;
      if (r) begin
         exp_valid = 1'b0;
         exp_sum = '0;
         exp_tag = "R1";
      end else if (v) begin
         exp_valid = 1'b1;
         exp_sum = e;
         exp_tag = tag;
      end else begin
         exp_valid = 1'b0;
         exp_tag = "R6";
      end
   endtask

   // Send one 4-bit word pair as two digits; optional idle cycles between them.
   task automatic send_word(input logic [3:0] a4, input logic [3:0] b4,
                            input logic prev_ovf, input int gap);
      logic [4:0] s;
      s = {1'b0, a4} + {1'b0, b4};
      tick(1'b0, 1'b1, a4[1:0], b4[1:0], s[1:0], prev_ovf ? "R4" : "R3");
      for (int g = 0; g < gap; g++) tick(1'b0, 1'b0, 2'b11, 2'b11, 2'b00, "R6");
      tick(1'b0, 1'b1, a4[3:2], b4[3:2], s[3:2], "R5");
   endtask

   initial begin
      #(CLK_P * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic prev;
      // R1: reset state, held for a few cycles
      for (int k = 0; k < 3; k++) tick(1'b1, 1'b0, 2'b00, 2'b00, 2'b00, "R1");

      // R3 R4 R5: every operand pair, back to back
      prev = 1'b0;
      for (int i = 0; i < 256; i++) begin
         logic [3:0] a4;
         logic [3:0] b4;
         a4 = 4'(i >> 4);
         b4 = 4'(i);
         send_word(a4, b4, prev, 0);
         prev = ({1'b0, a4} + {1'b0, b4}) > 5'd15;
      end

      // R6: idle cycles inside and between words must not disturb the sum
      for (int i = 0; i < 256; i += 7) begin
         logic [3:0] a4;
         logic [3:0] b4;
         a4 = 4'(i);
         b4 = 4'(i * 5 + 3);
         send_word(a4, b4, prev, 1 + (i % 3));
         prev = ({1'b0, a4} + {1'b0, b4}) > 5'd15;
         tick(1'b0, 1'b0, 2'b10, 2'b01, 2'b00, "R6");
      end

      // R1: reset in mid-word restarts the digit position; the carry is dropped
      send_word(4'hF, 4'hF, prev, 0);
      tick(1'b0, 1'b1, 2'b11, 2'b11, 2'b10, "R4");
      tick(1'b1, 1'b0, 2'b00, 2'b00, 2'b00, "R1");
      send_word(4'h3, 4'h1, 1'b1, 0);
      send_word(4'h9, 4'h8, 1'b0, 0);

      tick(1'b0, 1'b0, 2'b00, 2'b00, 2'b00, "R6");
      tick(1'b0, 1'b0, 2'b00, 2'b00, 2'b00, "R6");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule